// File: doc/BRIEF.md
# Guarded Configuration Copy Engine

This block runs after a 256-byte image has been loaded into a local register file. When it is started, and only if its enable input is high and the loader reports success, it reads a byte count and a start offset from two fixed bytes near the top of the image. It then copies a window of image bytes, in ascending order, into a bank of configuration registers. The first byte copied goes to configuration register 0, the next to register 1, and so on. At most one register is written per clock.

The copy is bounded. Two pointer values are reserved and mean that no copy is wanted. A count above the bank size is rejected and nothing is written. A window that would run into the top bytes of the image is cut short at a fixed offset, so the count, pointer and checksum bytes are never copied. Each run ends with a one-cycle done pulse and an ok flag. A two-bit result code is held until the next run starts.

Top module: `cfgcopy_engine`

## Requirements
- R1: A start while `enable_i` or `load_ok_i` is low performs no writes. It still gives one done pulse, with `ok_o` equal to `load_ok_i`.
- R2: The count N is read from image offset FDh and the start offset S from image offset FEh. Write k carries the image byte at offset S+k.
- R3: If S is 00h or FFh, no write takes place and the run ends with `ok_o`=1.
- R4: If N is greater than 40, no write takes place and the run ends with `ok_o`=0. This check wins over truncation.
- R5: If N is 0, the run ends with `ok_o`=1 and no write.
- R6: Write k targets `cfg_idx_o`=k, for k = 0 up to (number of writes minus 1). The writes fall on consecutive clocks, with at most one per clock, and `img_addr_o` rises by one per write.
- R7: The number of writes is min(N, 252-S), or 0 when S is 252 or more. No image offset at or above 252 is ever copied. A truncated run still ends with `ok_o`=1.
- R8: Every accepted run gives exactly one done pulse, one cycle long. `ok_o` is valid in that cycle, and no write happens in the done cycle.
- R9: `status_o` reads 00 after reset and 10 while a run is in progress. From the done cycle until the next start it reads 01 if the run succeeded and 11 if it failed.
- R10: A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| enable_i | input | 1 | Copy enable |
| load_ok_i | input | 1 | Image loader success flag |
| img_addr_o | output | 8 | Image read address |
| img_rdata_i | input | 8 | Image read data, combinational from address |
| cfg_we_o | output | 1 | Configuration register write strobe |
| cfg_idx_o | output | 6 | Configuration register index |
| cfg_data_o | output | 8 | Configuration register write data |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ok_o | output | 1 | Run success, valid with done |
| status_o | output | 2 | Held result code: 00 idle, 10 busy, 01 ok, 11 fail |

## Verification
Two guards can apply to the same request: the oversize rejection and the truncation at offset 252. A start offset of F0h with a count of 50 triggers both at once. The bench expects no writes and a failing result, because rejection takes priority. A reserved pointer combined with an oversize count is judged the same way, except that the pointer check wins and the result is ok. A second start pulse issued in the middle of a copy checks that the copy and a restart never overlap: the bench requires the write list to be unchanged and exactly one done pulse.

// File: rtl/cfgcopy_pkg.sv
// Shared types for the configuration copy engine.
package cfgcopy_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RD_SIZE = 3'd1,
        ST_RD_PTR  = 3'd2,
        ST_CHECK   = 3'd3,
        ST_COPY    = 3'd4,
        ST_DONE    = 3'd5
    } seq_state_t;

    // Held result code
    typedef enum logic [1:0] {
        STAT_IDLE = 2'b00,
        STAT_OK   = 2'b01,
        STAT_BUSY = 2'b10,
        STAT_FAIL = 2'b11
    } stat_code_t;

endpackage

// File: rtl/cfgcopy_window.sv
// cfgcopy_window: combinational bounds decision.
// It takes the latched count and start offset and reports three things:
// whether the pointer is reserved, whether the count is rejected, and the
// truncated copy length.
// Assumes: AW >= CW, and LIMIT <= 2**AW.
module cfgcopy_window #(
    parameter int AW      = 8,
    parameter int MAX_CNT = 40,
    parameter int LIMIT   = 252,
    parameter int CW      = 6
) (
    input  logic [AW-1:0] size_i,
    input  logic [AW-1:0] ptr_i,
    output logic          reserved_o,
    output logic          reject_o,
    output logic [CW-1:0] len_o
);
    logic [AW:0] room;
    logic [AW:0] size_ext;
    logic [AW:0] len_wide;

    // Reserved pointer values: all zeros or all ones
    assign reserved_o = (ptr_i == '0) || (ptr_i == '1);

    // An oversize count is rejected outright
    assign reject_o = ({1'b0, size_i} > (AW+1)'(MAX_CNT));

    // Number of bytes left below the limit offset
    always_comb begin
        size_ext = {1'b0, size_i};
        if ({1'b0, ptr_i} < (AW+1)'(LIMIT))
            room = (AW+1)'(LIMIT) - {1'b0, ptr_i};
        else
            room = '0;
        len_wide = (size_ext > room) ? room : size_ext;
    end

    assign len_o = CW'(len_wide);
endmodule

// File: rtl/cfgcopy_seq.sv
// cfgcopy_seq: run sequencer.
// It reads the count byte and then the pointer byte from the image. It then
// acts on the window decision and either issues one configuration write per
// clock or finishes at once.
// Assumes: image read data is valid in the same cycle as the address.
module cfgcopy_seq
    import cfgcopy_pkg::*;
#(
    parameter int           AW       = 8,
    parameter int           DW       = 8,
    parameter int           CW       = 6,
    parameter logic [AW-1:0] SIZE_OFS = 8'hFD,
    parameter logic [AW-1:0] PTR_OFS  = 8'hFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          enable_i,
    input  logic          load_ok_i,
    output logic [AW-1:0] img_addr_o,
    input  logic [DW-1:0] img_rdata_i,
    output logic [AW-1:0] size_o,
    output logic [AW-1:0] ptr_o,
    input  logic          reserved_i,
    input  logic          reject_i,
    input  logic [CW-1:0] len_i,
    output logic          cfg_we_o,
    output logic [CW-1:0] cfg_idx_o,
    output logic [DW-1:0] cfg_data_o,
    output logic          done_o,
    output logic          ok_o,
    output logic          accept_o,
    output logic          finish_o,
    output logic          finish_ok_o
);
    seq_state_t     state_q, state_d;
    logic [AW-1:0]  size_q, ptr_q;
    logic [CW-1:0]  len_q, cnt_q;
    logic           ok_q;
    logic           last_wr;

    assign last_wr = ((cnt_q + 1'b1) == len_q);

    // Next-state and end-of-run decision
    always_comb begin
        state_d     = state_q;
        finish_o    = 1'b0;
        finish_ok_o = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    if (enable_i && load_ok_i) begin
                        state_d = ST_RD_SIZE;
                    end else begin
                        state_d     = ST_DONE;
                        finish_o    = 1'b1;
                        finish_ok_o = load_ok_i;
                    end
                end
            end
            ST_RD_SIZE: state_d = ST_RD_PTR;
            ST_RD_PTR:  state_d = ST_CHECK;
            ST_CHECK: begin
                if (reserved_i) begin
                    state_d     = ST_DONE;
                    finish_o    = 1'b1;
                    finish_ok_o = 1'b1;
                end else if (reject_i) begin
                    state_d     = ST_DONE;
                    finish_o    = 1'b1;
                    finish_ok_o = 1'b0;
                end else if (len_i == '0) begin
                    state_d     = ST_DONE;
                    finish_o    = 1'b1;
                    finish_ok_o = 1'b1;
                end else begin
                    state_d = ST_COPY;
                end
            end
            ST_COPY: begin
                if (last_wr) begin
                    state_d     = ST_DONE;
                    finish_o    = 1'b1;
                    finish_ok_o = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Latch the count and pointer bytes as they are read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_q <= '0;
            ptr_q  <= '0;
        end else begin
            if (state_q == ST_RD_SIZE) size_q <= img_rdata_i;
            if (state_q == ST_RD_PTR)  ptr_q  <= img_rdata_i;
        end
    end

    // Copy length and running write index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            cnt_q <= '0;
        end else if (state_q == ST_CHECK) begin
            len_q <= len_i;
            cnt_q <= '0;
        end else if (state_q == ST_COPY && !last_wr) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Result flag, captured when the run finishes
    always_ff @(posedge clk) begin
        if (!rst_n)        ok_q <= 1'b0;
        else if (finish_o) ok_q <= finish_ok_o;
    end

    // Image address for each phase
    always_comb begin
        case (state_q)
            ST_RD_SIZE: img_addr_o = SIZE_OFS;
            ST_RD_PTR:  img_addr_o = PTR_OFS;
            ST_COPY:    img_addr_o = ptr_q + AW'(cnt_q);
            default:    img_addr_o = '0;
        endcase
    end

    assign size_o     = size_q;
    assign ptr_o      = ptr_q;
    assign cfg_we_o   = (state_q == ST_COPY);
    assign cfg_idx_o  = cnt_q;
    assign cfg_data_o = img_rdata_i;
    assign done_o     = (state_q == ST_DONE);
    assign ok_o       = ok_q;
    assign accept_o   = (state_q == ST_IDLE) && start_i;
endmodule

// File: rtl/cfgcopy_status.sv
// cfgcopy_status: held two-bit result code.
// The code is busy from an accepted start and shows the outcome from the end
// of the run. An end in the same cycle as the start takes priority.
module cfgcopy_status
    import cfgcopy_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       accept_i,
    input  logic       finish_i,
    input  logic       finish_ok_i,
    output logic [1:0] status_o
);
    stat_code_t stat_q;

    // Track the run phase and its outcome
    always_ff @(posedge clk) begin
        if (!rst_n)        stat_q <= STAT_IDLE;
        else if (finish_i) stat_q <= finish_ok_i ? STAT_OK : STAT_FAIL;
        else if (accept_i) stat_q <= STAT_BUSY;
    end

    assign status_o = stat_q;
endmodule

// File: rtl/cfgcopy_engine.sv
// cfgcopy_engine: top level of the guarded configuration copy engine.
// It joins the sequencer, the bounds decision and the result code.
// Assumes: a register-file image read port with zero latency.
module cfgcopy_engine #(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int MAX_CNT = 40,
    parameter int LIMIT   = 252,
    parameter logic [AW-1:0] SIZE_OFS = 8'hFD,
    parameter logic [AW-1:0] PTR_OFS  = 8'hFE,
    localparam int CW     = $clog2(MAX_CNT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          enable_i,
    input  logic          load_ok_i,
    output logic [AW-1:0] img_addr_o,
    input  logic [DW-1:0] img_rdata_i,
    output logic          cfg_we_o,
    output logic [CW-1:0] cfg_idx_o,
    output logic [DW-1:0] cfg_data_o,
    output logic          done_o,
    output logic          ok_o,
    output logic [1:0]    status_o
);
    logic [AW-1:0] size_w, ptr_w;
    logic          reserved_w, reject_w;
    logic [CW-1:0] len_w;
    logic          accept_w, finish_w, finish_ok_w;

    cfgcopy_window #(
        .AW(AW), .MAX_CNT(MAX_CNT), .LIMIT(LIMIT), .CW(CW)
    ) u_window (
        .size_i     (size_w),
        .ptr_i      (ptr_w),
        .reserved_o (reserved_w),
        .reject_o   (reject_w),
        .len_o      (len_w)
    );

    cfgcopy_seq #(
        .AW(AW), .DW(DW), .CW(CW), .SIZE_OFS(SIZE_OFS), .PTR_OFS(PTR_OFS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .enable_i    (enable_i),
        .load_ok_i   (load_ok_i),
        .img_addr_o  (img_addr_o),
        .img_rdata_i (img_rdata_i),
        .size_o      (size_w),
        .ptr_o       (ptr_w),
        .reserved_i  (reserved_w),
        .reject_i    (reject_w),
        .len_i       (len_w),
        .cfg_we_o    (cfg_we_o),
        .cfg_idx_o   (cfg_idx_o),
        .cfg_data_o  (cfg_data_o),
        .done_o      (done_o),
        .ok_o        (ok_o),
        .accept_o    (accept_w),
        .finish_o    (finish_w),
        .finish_ok_o (finish_ok_w)
    );

    cfgcopy_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept_w),
        .finish_i    (finish_w),
        .finish_ok_i (finish_ok_w),
        .status_o    (status_o)
    );
endmodule

// File: rtl/cfgcopy_engine_chk.sv
// cfgcopy_engine_chk: port-level temporal checks, bound to the top module.
module cfgcopy_engine_chk #(
    parameter int AW      = 8,
    parameter int MAX_CNT = 40,
    parameter int LIMIT   = 252,
    parameter int CW      = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we_o,
    input logic [CW-1:0] cfg_idx_o,
    input logic [AW-1:0] img_addr_o,
    input logic          done_o,
    input logic          ok_o,
    input logic [1:0]    status_o
);
    // R6: the index stays inside the bank
    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_o |-> (int'(cfg_idx_o) < MAX_CNT));

    // R6: back-to-back writes step the index by one
    assert_idx_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_o && $past(cfg_we_o)) |-> (cfg_idx_o == $past(cfg_idx_o) + 1'b1));

    // R6: back-to-back writes step the image address by one
    assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_o && $past(cfg_we_o)) |-> (img_addr_o == $past(img_addr_o) + 1'b1));

    // R7: no image byte at or above the limit is copied
    assert_below_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_o |-> (int'(img_addr_o) < LIMIT));

    // R8: done lasts exactly one cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: no write happens in the done cycle
    assert_no_write_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cfg_we_o);

    // R9: the code reads busy during a copy
    assert_busy_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_o |-> (status_o == 2'b10));

    // R9: the result code matches ok in the done cycle
    assert_result_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (status_o == (ok_o ? 2'b01 : 2'b11)));
endmodule

bind cfgcopy_engine cfgcopy_engine_chk #(
    .AW(AW), .MAX_CNT(MAX_CNT), .LIMIT(LIMIT), .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_o   (cfg_we_o),
    .cfg_idx_o  (cfg_idx_o),
    .img_addr_o (img_addr_o),
    .done_o     (done_o),
    .ok_o       (ok_o),
    .status_o   (status_o)
);

// File: tb/cfgcopy_engine_bench.sv
`timescale 1ns/1ps
// Bench for cfgcopy_engine: directed corner cases plus seeded random runs.
module cfgcopy_engine_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       enable_i = 1'b0;
    logic       load_ok_i = 1'b0;
    logic [7:0] img_addr;
    logic [7:0] img_rdata;
    logic       cfg_we;
    logic [5:0] cfg_idx;
    logic [7:0] cfg_data;
    logic       done;
    logic       ok;
    logic [1:0] status;

    logic [7:0] img_mem [256];
    assign img_rdata = img_mem[img_addr];

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    int         wr_n;
    logic [5:0] wr_idx [64];
    logic [7:0] wr_dat [64];
    int         wr_cyc [64];
    int         done_cnt;
    logic       last_ok;
    int         busy_bad;

    always #2.5 clk = ~clk;

    cfgcopy_engine u_cfgcopy_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .enable_i(enable_i),
        .load_ok_i(load_ok_i), .img_addr_o(img_addr), .img_rdata_i(img_rdata),
        .cfg_we_o(cfg_we), .cfg_idx_o(cfg_idx), .cfg_data_o(cfg_data),
        .done_o(done), .ok_o(ok), .status_o(status)
    );

    // Cycle counter and watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_we) begin
                if (wr_n < 64) begin
                    wr_idx[wr_n] = cfg_idx;
                    wr_dat[wr_n] = cfg_data;
                    wr_cyc[wr_n] = cyc;
                end
                wr_n++;
                if (status != 2'b10) busy_bad++;
            end
            if (done) begin
                done_cnt++;
                last_ok = ok;
            end
        end
    end

    task automatic check(input bit cond, input string what, input int act, input int exp);
        n_chk++;
        if (!cond) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [7:0] s, input logic [7:0] n, input logic go);
        int room;
        if (!go) return 0;
        if (s == 8'h00 || s == 8'hFF) return 0;
        if (n > 40) return 0;
        room = (s < 252) ? 252 - s : 0;
        return (int'(n) < room) ? int'(n) : room;
    endfunction

    function automatic logic exp_ok(input logic [7:0] s, input logic [7:0] n,
                                    input logic en, input logic lok);
        if (!(en && lok)) return lok;
        if (s == 8'h00 || s == 8'hFF) return 1'b1;
        return (n <= 40);
    endfunction

    task automatic run_case(input logic [7:0] s, input logic [7:0] n,
                            input logic en, input logic lok, input bit restart);
        int    len;
        logic  eok;
        string rq;
        int    room;
        bit    dat_good;
        bit    seq_good;
        int    tmo;
        for (int i = 0; i < 256; i++) img_mem[i] = 8'($urandom);
        img_mem[8'hFD] = n;
        img_mem[8'hFE] = s;
        len  = exp_len(s, n, en && lok);
        eok  = exp_ok(s, n, en, lok);
        room = (s < 252) ? 252 - s : 0;
        if (!(en && lok))                 rq = "R1";
        else if (s == 8'h00 || s == 8'hFF) rq = "R3";
        else if (n > 40)                  rq = "R4";
        else if (n == 0)                  rq = "R5";
        else if (room < int'(n))          rq = "R7";
        else                              rq = "R6";
        @(posedge clk); #1;
        wr_n = 0; done_cnt = 0; busy_bad = 0; last_ok = 1'bx;
        @(negedge clk);
        enable_i = en; load_ok_i = lok; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (restart) begin
            // R10: second start in the middle of the copy
            repeat (8) @(negedge clk);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        tmo = 0;
        while (done_cnt == 0 && tmo < 300) begin
            @(posedge clk); #1;
            tmo++;
        end
        repeat (6) @(posedge clk);
        #1;
        check(wr_n == len, {rq, " write count (R2 bounds)"}, wr_n, len);
        dat_good = 1'b1;
        seq_good = 1'b1;
        for (int i = 0; i < len && i < wr_n; i++) begin
            if (wr_idx[i] != 6'(i) || wr_dat[i] != img_mem[8'(s + 8'(i))]) dat_good = 1'b0;
            if (wr_cyc[i] != wr_cyc[0] + i) seq_good = 1'b0;
        end
        check(dat_good, "R2 index/data of copied bytes", int'(dat_good), 1);
        check(seq_good, "R6 writes on consecutive clocks", int'(seq_good), 1);
        check(done_cnt == 1, restart ? "R10 single done with restart" : "R8 done pulse count",
              done_cnt, 1);
        check(last_ok === eok, {rq, " ok flag (R8)"}, int'(last_ok), int'(eok));
        check(status == (eok ? 2'b01 : 2'b11), "R9 held result code",
              int'(status), eok ? 1 : 3);
        check(busy_bad == 0, "R9 busy code during copy", busy_bad, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) img_mem[i] = 8'h00;
        repeat (5) @(posedge clk);
        #1;
        check(status == 2'b00, "R9 reset code", int'(status), 0);
        check(done == 1'b0 && cfg_we == 1'b0, "R8 quiet in reset", int'({done, cfg_we}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(status == 2'b00, "R9 idle code after reset", int'(status), 0);

        run_case(8'h80, 8'd10, 1, 1, 0);   // R6 plain copy
        run_case(8'h00, 8'd10, 1, 1, 0);   // R3
        run_case(8'hFF, 8'd10, 1, 1, 0);   // R3
        run_case(8'h80, 8'd41, 1, 1, 0);   // R4
        run_case(8'h80, 8'd40, 1, 1, 0);   // R6 full bank
        run_case(8'hF0, 8'd50, 1, 1, 0);   // R4 beats R7
        run_case(8'h00, 8'd50, 1, 1, 0);   // R3 beats R4
        run_case(8'hF0, 8'd20, 1, 1, 0);   // R7 truncates to 12
        run_case(8'hFB, 8'd5,  1, 1, 0);   // R7 truncates to 1
        run_case(8'hFC, 8'd3,  1, 1, 0);   // R7 nothing left
        run_case(8'hE0, 8'd28, 1, 1, 0);   // R7 ends exactly at limit
        run_case(8'h90, 8'd0,  1, 1, 0);   // R5
        run_case(8'h80, 8'd10, 0, 1, 0);   // R1 disabled
        run_case(8'h80, 8'd10, 1, 0, 0);   // R1 loader failed
        run_case(8'h80, 8'd30, 1, 1, 1);   // R10 restart ignored

        for (int k = 0; k < 60; k++) begin
            logic [7:0] rs, rn;
            logic       ren, rlok;
            rs   = ($urandom % 4 == 0) ? 8'(8'hE8 + $urandom % 24) : 8'($urandom);
            rn   = 8'($urandom % 48);
            ren  = ($urandom % 8) != 0;
            rlok = ($urandom % 8) != 0;
            run_case(rs, rn, ren, rlok, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule